// File: doc/BRIEF.md
# Strobed Serial Command Decoder for an LED Display Controller

This block sits at the host side of a multiplexed LED display controller. It receives bytes over a three-wire link made of a strobe, a shift clock and a data line. It decodes each transfer into register updates or display RAM writes. The block works in the system clock domain. It runs all three serial inputs through two-flop synchronisers and detects shift-clock rising edges after them. The link is therefore expected to toggle several system clocks apart.

Each transfer begins when the strobe falls. The first complete byte is a command, and its two top bits select one of four classes:
- **Mode:** sets the grid and segment layout.
- **Data setting:** sets the write target, fixed or stepping address, and test flag.
- **Display control:** sets on/off and brightness, held for the scanner.
- **Address:** sets the RAM pointer. The bytes that follow it in the same transfer are stored into a 14-byte display RAM.

A scanner reads the RAM through a combinational read port.

The controller is a four-state machine:
- **ST_IDLE:** strobe high.
- **ST_CMD:** strobe low, waiting for the command byte.
- **ST_WRITE:** after an address command; data bytes go to RAM.
- **ST_IGNORE:** after any other command; further bytes are dropped.

Transitions:
- ST_IDLE goes to ST_CMD on strobe low.
- ST_CMD goes to ST_WRITE on an address command.
- ST_CMD goes to ST_IGNORE on any other command.
- Every state returns to ST_IDLE when the strobe is high.

Top module: `disp_cmd_rx`

## Requirements
- R1: Data is sampled on rising edges of `ser_clk`, least significant bit first, only while `ser_stb` is low. Clock edges while `ser_stb` is high have no effect on later transfers.
- R2: The first full byte after `ser_stb` falls is a command. Its bits [7:6] select the class: 00 mode, 01 data setting, 10 display control, 11 address.
- R3: If `ser_stb` rises before a byte is complete, the partial byte is dropped. The next transfer starts at bit 0 with a command.
- R4: A mode command loads `mode_sel` from bits [1:0], and bits [5:2] are ignored. A value different from the current mode also clears `disp_on`. Repeating the current mode changes nothing.
- R5: A data-setting command loads `addr_fixed` from bit 2, `test_mode` from bit 3 and `write_sel` from bits [1:0]. Data bytes reach the RAM only while `write_sel` is 00.
- R6: An address command loads `cur_addr` from bits [3:0]. Each following byte in the same transfer is stored at `cur_addr`.
- R7: While `cur_addr` is 0xE or 0xF, data bytes are dropped and the RAM is unchanged.
- R8: When `addr_fixed` is 0, `cur_addr` rises by one after each stored byte. Past 0xD it stays at 0xE and later bytes are dropped. When `addr_fixed` is 1, `cur_addr` does not move.
- R9: A display-control command loads `disp_on` from bit 3 and `dim_level` from bits [2:0].
- R10: After reset the outputs are as follows:
  - `mode_sel` is 11.
  - `disp_on`, `dim_level`, `addr_fixed`, `test_mode`, `write_sel` and `cur_addr` are all zero.
  - Every RAM byte is zero.
- R11: Bytes that follow a mode, data-setting or display-control command in the same transfer are ignored.
- R12: `scan_data` shows RAM byte `scan_addr` combinationally. It shows zero for `scan_addr` 0xE and 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_stb | input | 1 | Serial strobe, low during a transfer |
| ser_clk | input | 1 | Serial shift clock, rising-edge sampled |
| ser_din | input | 1 | Serial data, LSB first |
| scan_addr | input | 4 | Scanner read address |
| scan_data | output | 8 | RAM byte at scan_addr |
| mode_sel | output | 2 | Grid/segment layout code |
| disp_on | output | 1 | Display enable |
| dim_level | output | 3 | Brightness step |
| addr_fixed | output | 1 | 1 = address does not step |
| test_mode | output | 1 | Test flag |
| write_sel | output | 2 | Write target, 00 = display RAM |
| cur_addr | output | 4 | Current RAM pointer |

## Verification
A shifter that slips one bit shows up at the end of the same transfer. The command byte decodes as the wrong class, and a register or `cur_addr` disagrees with the model once the strobe rises. A stuck state or wrong pointer arithmetic leaves `cur_addr` off after a single data byte. A write that escapes past 0xD, or lands while the mode forbids it, shows up on the next full sweep of the read port. The bench makes that sweep at the end of every directed step and every few random transfers.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;
    localparam int BYTE_W    = 8;
    localparam int RAM_DEPTH = 14;
    localparam int ADDR_W    = 4;
    localparam int DIM_W     = 3;
    localparam int MODE_W    = 2;

    typedef enum logic [1:0] {
        CMD_MODE = 2'b00,
        CMD_DATA = 2'b01,
        CMD_CTRL = 2'b10,
        CMD_ADDR = 2'b11
    } cmd_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WRITE,
        ST_IGNORE
    } rx_state_e;

    typedef struct packed {
        logic       test;
        logic       fixed;
        logic [1:0] wsel;
    } data_cfg_t;
endpackage

// File: rtl/disp_cmd_sync.sv
module disp_cmd_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RESET_VAL[g]}};
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[g]};
                end
            end
            assign sync_out[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/disp_cmd_shift.sv
module disp_cmd_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              sck,
    input  logic              din,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_first
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sck_q;
    logic              sck_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              first_pend;

    assign sck_rise = sck && !sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q      <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            first_pend <= 1'b1;
            byte_vld   <= 1'b0;
            byte_data  <= '0;
            byte_first <= 1'b0;
        end else begin
            sck_q    <= sck;
            byte_vld <= 1'b0;
            if (stb) begin
                bit_cnt    <= '0;
                shreg      <= '0;
                first_pend <= 1'b1;
            end else if (sck_rise) begin
                shreg <= {din, shreg[BYTE_W-1:1]};
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    bit_cnt    <= '0;
                    byte_vld   <= 1'b1;
                    byte_data  <= {din, shreg[BYTE_W-1:1]};
                    byte_first <= first_pend;
                    first_pend <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

    AST_FLUSH_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb) |=> (bit_cnt == '0 && first_pend)); // R3
    AST_NO_BYTE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && $past(stb)) |-> !byte_vld); // R1
endmodule

// File: rtl/disp_cmd_ram.sv
module disp_cmd_ram #(
    parameter int DEPTH  = 14,
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (we && waddr == ADDR_W'(g)) begin
                    mem[g] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == ADDR_W'(i)) begin
                rdata = mem[i];
            end
        end
    end

    AST_WE_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH)); // R7
endmodule

// File: rtl/disp_cmd_ctrl.sv
module disp_cmd_ctrl
    import disp_cmd_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int RAM_DEPTH = 14,
    parameter int ADDR_W    = 4,
    parameter int DIM_W     = 3,
    parameter int MODE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_first,
    output logic [MODE_W-1:0] mode,
    output logic              disp_on,
    output logic [DIM_W-1:0]  dim,
    output data_cfg_t         cfg,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [BYTE_W-1:0] ram_wdata
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(RAM_DEPTH - 1);
    localparam logic [MODE_W-1:0] MODE_RST  = '1;

    rx_state_e  state, state_nx;
    cmd_class_e cls;
    logic       cmd_take;
    logic       addr_ok;
    logic       cmd_unused;

    assign cls        = cmd_class_e'(byte_data[BYTE_W-1:BYTE_W-2]);
    assign cmd_take   = (state == ST_CMD) && byte_vld && byte_first && !stb;
    assign addr_ok    = (cur_addr <= LAST_ADDR);
    assign cmd_unused = ^byte_data[5:4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!stb) state_nx = ST_CMD;
            end
            ST_CMD: begin
                if (stb) begin
                    state_nx = ST_IDLE;
                end else if (cmd_take) begin
                    state_nx = (cls == CMD_ADDR) ? ST_WRITE : ST_IGNORE;
                end
            end
            ST_WRITE: begin
                if (stb) state_nx = ST_IDLE;
            end
            ST_IGNORE: begin
                if (stb) state_nx = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        ram_we    = (state == ST_WRITE) && byte_vld && !stb
                    && addr_ok && (cfg.wsel == 2'b00);
        ram_waddr = cur_addr;
        ram_wdata = byte_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= MODE_RST;
            disp_on  <= 1'b0;
            dim      <= '0;
            cfg      <= '0;
            cur_addr <= '0;
        end else if (cmd_take) begin
            unique case (cls)
                CMD_MODE: begin
                    if (byte_data[MODE_W-1:0] != mode) begin
                        mode    <= byte_data[MODE_W-1:0];
                        disp_on <= 1'b0;
                    end
                end
                CMD_DATA: begin
                    cfg.wsel  <= byte_data[1:0];
                    cfg.fixed <= byte_data[2];
                    cfg.test  <= byte_data[3];
                end
                CMD_CTRL: begin
                    disp_on <= byte_data[3];
                    dim     <= byte_data[DIM_W-1:0];
                end
                CMD_ADDR: begin
                    cur_addr <= byte_data[ADDR_W-1:0];
                end
            endcase
        end else if (ram_we && !cfg.fixed) begin
            cur_addr <= cur_addr + ADDR_W'(1);
        end
    end

    AST_MODE_CHANGE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> !disp_on); // R4
    AST_CMD_IS_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && byte_vld && !stb) |-> byte_first); // R2
    AST_IDLE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (state == ST_IDLE)); // R3
    AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ram_we && !cfg.fixed) |-> (cur_addr == $past(cur_addr) + ADDR_W'(1))); // R8
    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ram_we && cfg.fixed) |-> $stable(cur_addr)); // R8
    AST_NO_WRITE_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_addr > LAST_ADDR) |-> !ram_we); // R7
endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx
    import disp_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_stb,
    input  logic                 ser_clk,
    input  logic                 ser_din,
    input  logic [ADDR_W-1:0]    scan_addr,
    output logic [BYTE_W-1:0]    scan_data,
    output logic [MODE_W-1:0]    mode_sel,
    output logic                 disp_on,
    output logic [DIM_W-1:0]     dim_level,
    output logic                 addr_fixed,
    output logic                 test_mode,
    output logic [1:0]           write_sel,
    output logic [ADDR_W-1:0]    cur_addr
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_in, sync_in;
    logic              stb_s, sck_s, din_s;
    logic              byte_vld, byte_first;
    logic [BYTE_W-1:0] byte_data;
    data_cfg_t         cfg;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [BYTE_W-1:0] ram_wdata;

    assign raw_in = {ser_stb, ser_clk, ser_din};
    assign {stb_s, sck_s, din_s} = sync_in;

    disp_cmd_sync #(
        .WIDTH    (SYNC_W),
        .STAGES   (2),
        .RESET_VAL(3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_in),
        .sync_out(sync_in)
    );

    disp_cmd_shift #(
        .BYTE_W(BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (stb_s),
        .sck       (sck_s),
        .din       (din_s),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_first(byte_first)
    );

    disp_cmd_ctrl #(
        .BYTE_W   (BYTE_W),
        .RAM_DEPTH(RAM_DEPTH),
        .ADDR_W   (ADDR_W),
        .DIM_W    (DIM_W),
        .MODE_W   (MODE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (stb_s),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_first(byte_first),
        .mode      (mode_sel),
        .disp_on   (disp_on),
        .dim       (dim_level),
        .cfg       (cfg),
        .cur_addr  (cur_addr),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata)
    );

    disp_cmd_ram #(
        .DEPTH (RAM_DEPTH),
        .WIDTH (BYTE_W),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(ram_wdata),
        .raddr(scan_addr),
        .rdata(scan_data)
    );

    assign addr_fixed = cfg.fixed;
    assign test_mode  = cfg.test;
    assign write_sel  = cfg.wsel;
endmodule

// File: tb/disp_cmd_rx_bench.sv
module disp_cmd_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_stb = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic [3:0] scan_addr = '0;
    logic [7:0] scan_data;
    logic [1:0] mode_sel;
    logic       disp_on;
    logic [2:0] dim_level;
    logic       addr_fixed;
    logic       test_mode;
    logic [1:0] write_sel;
    logic [3:0] cur_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [1:0] m_mode;
    logic       m_on;
    logic [2:0] m_dim;
    logic       m_fixed, m_test;
    logic [1:0] m_wsel;
    logic [3:0] m_addr;
    logic [7:0] m_ram [14];
    logic [7:0] tx [8];

    always #2 clk = ~clk;

    disp_cmd_rx u_disp_cmd_rx (
        .clk(clk), .rst_n(rst_n), .ser_stb(ser_stb), .ser_clk(ser_clk),
        .ser_din(ser_din), .scan_addr(scan_addr), .scan_data(scan_data),
        .mode_sel(mode_sel), .disp_on(disp_on), .dim_level(dim_level),
        .addr_fixed(addr_fixed), .test_mode(test_mode), .write_sel(write_sel),
        .cur_addr(cur_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        report();
    end

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            ser_din = b[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic stb_fall();
        ser_stb = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic stb_rise();
        repeat (4) @(negedge clk);
        ser_stb = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic model(input logic [7:0] cmd, input int n);
        case (cmd[7:6])
            2'b00: if (cmd[1:0] != m_mode) begin m_mode = cmd[1:0]; m_on = 1'b0; end
            2'b01: begin m_wsel = cmd[1:0]; m_fixed = cmd[2]; m_test = cmd[3]; end
            2'b10: begin m_on = cmd[3]; m_dim = cmd[2:0]; end
            default: begin
                m_addr = cmd[3:0];
                for (int i = 0; i < n; i++) begin
                    if (m_wsel == 2'b00 && m_addr <= 4'hD) begin
                        m_ram[m_addr] = tx[i];
                        if (!m_fixed) m_addr = m_addr + 4'd1;
                    end
                end
            end
        endcase
    endtask

    task automatic txn(input logic [7:0] cmd, input int n);
        stb_fall();
        send_bits(cmd, 8);
        for (int i = 0; i < n; i++) send_bits(tx[i], 8);
        stb_rise();
        model(cmd, n);
    endtask

    task automatic check_regs(input string tag);
        check({tag, " mode_sel"}, 32'(mode_sel), 32'(m_mode));
        check({tag, " disp_on"}, 32'(disp_on), 32'(m_on));
        check({tag, " dim_level"}, 32'(dim_level), 32'(m_dim));
        check({tag, " addr_fixed"}, 32'(addr_fixed), 32'(m_fixed));
        check({tag, " test_mode"}, 32'(test_mode), 32'(m_test));
        check({tag, " write_sel"}, 32'(write_sel), 32'(m_wsel));
        check({tag, " cur_addr"}, 32'(cur_addr), 32'(m_addr));
    endtask

    task automatic check_ram(input string tag);
        for (int i = 0; i < 16; i++) begin
            scan_addr = 4'(i);
            #1;
            check($sformatf("%s R12 ram[%0d]", tag, i), 32'(scan_data),
                  (i < 14) ? 32'(m_ram[i]) : 32'h0);
        end
    endtask

    initial begin
        logic [7:0] c;
        int         n;
        void'($urandom(32'd20240611));
        m_mode = 2'b11; m_on = 0; m_dim = 0; m_fixed = 0; m_test = 0;
        m_wsel = 0; m_addr = 0;
        for (int i = 0; i < 14; i++) m_ram[i] = 8'h00;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_regs("R10 reset");
        check_ram("R10 reset");

        txn(8'h8D, 0);                      check_regs("R9 ctrl on dim5");
        check(   "R9 dim explicit", 32'(dim_level), 32'd5);
        txn(8'h3F, 0);                      check_regs("R4 same mode");
        check(   "R4 on kept", 32'(disp_on), 32'd1);
        txn(8'h01, 0);                      check_regs("R4 mode change");
        check(   "R4 blanked", 32'(disp_on), 32'd0);

        txn(8'h40, 0);
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'hA5;
        txn(8'hC0, 3);                      check_regs("R6 R8 incr");
        check_ram("R6 R1");

        txn(8'h44, 0);
        tx[0] = 8'hAA; tx[1] = 8'hBB;
        txn(8'hC5, 2);                      check_regs("R8 R5 fixed");
        check_ram("R8 fixed");

        txn(8'h40, 0);
        tx[0] = 8'h01; tx[1] = 8'h02; tx[2] = 8'h03; tx[3] = 8'h04;
        txn(8'hCC, 4);                      check_regs("R8 top end");
        check(   "R8 parks at E", 32'(cur_addr), 32'hE);
        check_ram("R8 top end");

        tx[0] = 8'h77;
        txn(8'hCE, 1);                      check_regs("R7 bad addr");
        check_ram("R7 bad addr");

        txn(8'h41, 0);
        tx[0] = 8'h99;
        txn(8'hC0, 1);                      check_regs("R5 wsel 01");
        check_ram("R5 wsel 01");
        txn(8'h48, 0);                      check_regs("R5 test bit");

        tx[0] = 8'hC3; tx[1] = 8'h8F;
        txn(8'h80, 2);                      check_regs("R11 trailing");
        txn(8'h40, 0);
        tx[0] = 8'hC9;
        txn(8'h02, 1);                      check_regs("R11 after mode");

        stb_fall();
        send_bits(8'h8F, 4);
        stb_rise();                         check_regs("R3 partial cmd");
        txn(8'h8A, 0);                      check_regs("R3 realign");

        tx[0] = 8'h3C;
        txn(8'hC7, 0);
        stb_fall();
        send_bits(8'hC7, 8);
        send_bits(8'hFF, 5);
        stb_rise();                         check_regs("R3 partial data");
        check_ram("R3 partial data");

        ser_stb = 1'b1;
        send_bits(8'hFF, 3);
        txn(8'h8B, 0);                      check_regs("R1 idle clocks");
        check(   "R2 R1 dim", 32'(dim_level), 32'd3);

        for (int k = 0; k < 110; k++) begin
            case ($urandom % 8)
                0:       c = {2'b00, 4'($urandom), 2'($urandom)};
                1, 2:    c = {2'b01, 2'($urandom), 1'($urandom),
                              ($urandom % 4 == 0) ? 2'($urandom) : 2'b00};
                3:       c = {2'b10, 6'($urandom)};
                default: c = {2'b11, 2'($urandom), 4'($urandom)};
            endcase
            n = $urandom % 5;
            for (int i = 0; i < 8; i++) tx[i] = 8'($urandom);
            txn(c, n);
            check_regs("R2 random");
            if (k % 10 == 9) check_ram("R6 random");
        end
        check_ram("R6 final");
        report();
    end
endmodule